// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps time of day and the calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-second tick, qualified by a three-bit oscillator control field, advances an internal count that is always binary. The count is shown on seven visible time registers, encoded in BCD or binary and in 12-hour or 24-hour form as chosen by two mode inputs. Each accepted tick opens an update window that lasts a parameterised number of clock cycles. The window is flagged on `uip_o`. When it closes, the visible registers are refreshed, the alarm is compared, and the status flags and interrupt request are updated.

New time is written through a load port in the currently selected format. With SET low, a load updates the visible registers at once and the internal count one cycle later. With SET high, the visible registers are frozen against refresh and take loads, and the internal count takes them when SET drops. Leap years follow the full Gregorian rule. The century comes from the parameter `BASE_YEAR`, which must be a multiple of 100.

Top module: `rtc_calendar`

## Requirements
- R1: A tick advances the count only when `osc_i` equals 3'b010. With any other value the tick is ignored: no UIP, no flag and no change of time.
- R2: Seconds and minutes carry at 60, hours at 24, and days at the end of the month. Months have 31,28,31,30,31,30,31,31,30,31,30,31 days. February has 29 days when the full year (BASE_YEAR plus the two-digit year) is divisible by 4 and either not by 100 or by 400.
- R3: Day of week runs 1 to 7 and wraps to 1. Month runs 1 to 12 and wraps to 1, which increments the year. The year counts modulo 100, so 99 wraps to 00.
- R4: With `bin_mode_i` high every field is plain binary. With it low every field is BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R5: With `hr24_i` high the hour is 0 to 23. With it low the hour register holds hour modulo 12 in bits 6:0 and bit 7 is set for hours 12 to 23.
- R6: A tick accepted while SET is low raises `uip_o` on the next cycle and holds it for UIP_DLY cycles. On the cycle it falls, the visible registers show the new time and UF is set.
- R7: Each completed update sets flag bit 4 (UF). It also sets bit 7 (IRQF) and `irq_o` only when `upd_irq_en_i` is high.
- R8: An alarm field whose bits 7:6 are both 1 matches any value. Otherwise the field is decoded in the current format and compared with the count. When all three fields match at the end of an update and `alarm_en_i` is high, flag bits 7 and 5 are set and `irq_o` is raised. With `alarm_en_i` low, flag bit 5 stays clear.
- R9: While SET is high the visible registers are not refreshed and `uip_o` stays low, but UF is still set. A load during SET changes only the visible registers. When SET falls, the count restarts from the visible registers.
- R10: A load with SET low shows the loaded bytes on the next cycle, and counting continues from them.
- R11: After reset the time reads 00:00:00 on day 1 of month 1 of year 00, with day of week 1 and all flags, `uip_o` and `irq_o` clear. `flag_clr_i` clears all flags and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per second |
| osc_i | input | 3 | Oscillator control; 3'b010 runs |
| bin_mode_i | input | 1 | 1 binary, 0 BCD |
| hr24_i | input | 1 | 1 24-hour, 0 12-hour |
| set_i | input | 1 | Freeze visible registers for setting |
| alarm_en_i | input | 1 | Alarm interrupt enable |
| upd_irq_en_i | input | 1 | Update-ended interrupt enable |
| alarm_sec_i | input | 8 | Alarm seconds |
| alarm_min_i | input | 8 | Alarm minutes |
| alarm_hr_i | input | 8 | Alarm hours |
| load_i | input | 1 | Load strobe |
| load_sec_i | input | 8 | Load seconds |
| load_min_i | input | 8 | Load minutes |
| load_hr_i | input | 8 | Load hours |
| load_wday_i | input | 8 | Load day of week |
| load_mday_i | input | 8 | Load day of month |
| load_mon_i | input | 8 | Load month |
| load_year_i | input | 8 | Load year |
| flag_clr_i | input | 1 | Clear flags and interrupt |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hr_o | output | 8 | Hours |
| wday_o | output | 8 | Day of week |
| mday_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year |
| uip_o | output | 1 | Update in progress |
| flags_o | output | 8 | Flags: 7 IRQF, 5 AF, 4 UF |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the far rollovers: New Year, February 28 in leap and non-leap years and in a year divisible by 400, and the 11 PM to midnight step in 12-hour form. Reaching them by counting seconds would take days of ticks. The stimulus instead loads a time one second before each boundary, in the mode under test, and issues a single tick. The SET interplay is reached the same way. The bench loads while SET is high, confirms the frozen registers, and then observes that counting resumes from the loaded bytes once SET falls.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_WDAY = 3;
  localparam int F_MDAY = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int NFIELD = 7;

  typedef struct packed {
    logic [6:0] year;  // 0..99
    logic [3:0] mon;   // 1..12
    logic [4:0] mday;  // 1..31
    logic [2:0] wday;  // 0..6
    logic [4:0] hr;    // 0..23
    logic [5:0] min;
    logic [5:0] sec;
  } tm_t;

  function automatic logic [7:0] enc8(input logic [6:0] v, input logic bin);
    logic [6:0] t;
    logic [6:0] o;
    t = v / 7'd10;
    o = v - t * 7'd10;
    return bin ? {1'b0, v} : {t[3:0], o[3:0]};
  endfunction

  function automatic logic [7:0] dec8(input logic [7:0] r, input logic bin);
    return bin ? r : (8'({4'd0, r[7:4]}) * 8'd10 + 8'({4'd0, r[3:0]}));
  endfunction

  function automatic logic [7:0] enc_hr(input logic [4:0] h, input logic bin, input logic h24);
    logic [4:0] h12;
    h12 = (h >= 5'd12) ? h - 5'd12 : h;
    if (h24) return enc8({2'b0, h}, bin);
    return {h >= 5'd12, 7'(enc8({2'b0, h12}, bin))};
  endfunction

  function automatic logic [4:0] dec_hr(input logic [7:0] r, input logic bin, input logic h24);
    logic [7:0] d;
    if (h24) return 5'(dec8(r, bin));
    d = dec8({1'b0, r[6:0]}, bin);
    return 5'(d + (r[7] ? 8'd12 : 8'd0));
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  function automatic tm_t regs_to_tm(input logic [NFIELD-1:0][7:0] r,
                                     input logic bin, input logic h24);
    tm_t t;
    logic [7:0] w;
    t.sec  = 6'(dec8(r[F_SEC], bin));
    t.min  = 6'(dec8(r[F_MIN], bin));
    t.hr   = dec_hr(r[F_HR], bin, h24);
    w      = dec8(r[F_WDAY], bin) - 8'd1;
    t.wday = w[2:0];
    t.mday = 5'(dec8(r[F_MDAY], bin));
    t.mon  = 4'(dec8(r[F_MON], bin));
    t.year = 7'(dec8(r[F_YEAR], bin));
    return t;
  endfunction
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic load_i,
  input  tm_t  load_tm_i,
  output tm_t  tm_o
);
  localparam bit BASE_400 = (BASE_YEAR % 400) == 0;

  tm_t tm_q, tm_n;
  logic leap;
  logic [4:0] dim;

  assign leap = (tm_q.year[1:0] == 2'd0) && ((tm_q.year != 7'd0) || BASE_400);
  assign dim  = month_days(tm_q.mon, leap);

  always_comb begin
    tm_n = tm_q;
    if (tm_q.sec != 6'd59) tm_n.sec = tm_q.sec + 6'd1;
    else begin
      tm_n.sec = '0;
      if (tm_q.min != 6'd59) tm_n.min = tm_q.min + 6'd1;
      else begin
        tm_n.min = '0;
        if (tm_q.hr != 5'd23) tm_n.hr = tm_q.hr + 5'd1;
        else begin
          tm_n.hr   = '0;
          tm_n.wday = (tm_q.wday >= 3'd6) ? 3'd0 : tm_q.wday + 3'd1;
          if (tm_q.mday < dim) tm_n.mday = tm_q.mday + 5'd1;
          else begin
            tm_n.mday = 5'd1;
            if (tm_q.mon < 4'd12) tm_n.mon = tm_q.mon + 4'd1;
            else begin
              tm_n.mon  = 4'd1;
              tm_n.year = (tm_q.year >= 7'd99) ? 7'd0 : tm_q.year + 7'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tm_q <= '{year: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd0,
                           hr: 5'd0, min: 6'd0, sec: 6'd0};
    else if (load_i) tm_q <= load_tm_i;
    else if (step_i) tm_q <= tm_n;
  end

  assign tm_o = tm_q;

  assert_sec_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && tm_q.sec == 6'd59) |=> (tm_q.sec == 6'd0 && tm_q.min != $past(tm_q.min)));

  assert_sec_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && tm_q.sec < 6'd59) |=> (tm_q.sec == $past(tm_q.sec) + 6'd1));

  assert_wday_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && tm_q.sec == 6'd59 && tm_q.min == 6'd59 && tm_q.hr == 5'd23
     && tm_q.wday == 3'd6) |=> (tm_q.wday == 3'd0));
endmodule

// File: rtl/rtc_fmt.sv
module rtc_fmt
  import rtc_pkg::*;
(
  input  tm_t                     tm_i,
  input  logic                    bin_i,
  input  logic                    h24_i,
  output logic [NFIELD-1:0][7:0]  regs_o
);
  logic [NFIELD-1:0][6:0] val;

  assign val[F_SEC]  = {1'b0, tm_i.sec};
  assign val[F_MIN]  = {1'b0, tm_i.min};
  assign val[F_HR]   = {2'b0, tm_i.hr};
  assign val[F_WDAY] = {4'b0, tm_i.wday} + 7'd1;
  assign val[F_MDAY] = {2'b0, tm_i.mday};
  assign val[F_MON]  = {3'b0, tm_i.mon};
  assign val[F_YEAR] = tm_i.year;

  for (genvar i = 0; i < NFIELD; i++) begin : g_enc
    if (i == F_HR) begin : g_hr
      assign regs_o[i] = enc_hr(tm_i.hr, bin_i, h24_i);
    end else begin : g_plain
      assign regs_o[i] = enc8(val[i], bin_i);
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  tm_t             tm_i,
  input  logic [2:0][7:0] alarm_i,   // 0 sec, 1 min, 2 hr
  input  logic            bin_i,
  input  logic            h24_i,
  output logic            match_o
);
  logic [2:0][7:0] cur;
  logic [2:0]      hit;

  assign cur[0] = {2'b0, tm_i.sec};
  assign cur[1] = {2'b0, tm_i.min};
  assign cur[2] = {3'b0, tm_i.hr};

  for (genvar i = 0; i < 3; i++) begin : g_fld
    logic [7:0] want;
    if (i == 2) begin : g_hr
      assign want = {3'b0, dec_hr(alarm_i[i], bin_i, h24_i)};
    end else begin : g_ms
      assign want = dec8(alarm_i[i], bin_i);
    end
    assign hit[i] = (alarm_i[i][7:6] == 2'b11) || (want == cur[i]);
  end

  assign match_o = &hit;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int BASE_YEAR = 2000,
  parameter int UIP_DLY   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [2:0] osc_i,
  input  logic       bin_mode_i,
  input  logic       hr24_i,
  input  logic       set_i,
  input  logic       alarm_en_i,
  input  logic       upd_irq_en_i,
  input  logic [7:0] alarm_sec_i,
  input  logic [7:0] alarm_min_i,
  input  logic [7:0] alarm_hr_i,
  input  logic       load_i,
  input  logic [7:0] load_sec_i,
  input  logic [7:0] load_min_i,
  input  logic [7:0] load_hr_i,
  input  logic [7:0] load_wday_i,
  input  logic [7:0] load_mday_i,
  input  logic [7:0] load_mon_i,
  input  logic [7:0] load_year_i,
  input  logic       flag_clr_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       uip_o,
  output logic [7:0] flags_o,
  output logic       irq_o
);
  localparam int          CW      = $clog2(UIP_DLY + 1);
  localparam logic [2:0]  OSC_RUN = 3'b010;

  logic [NFIELD-1:0][7:0] vis_q, enc, ld;
  tm_t        tm, ld_tm;
  logic       busy_q, uip_q, sync_q, set_q;
  logic [CW-1:0] cnt_q;
  logic       tick_run, step, end_ev, alarm_hit, afire;
  logic [7:0] flags_q, flags_new;

  assign ld[F_SEC]  = load_sec_i;
  assign ld[F_MIN]  = load_min_i;
  assign ld[F_HR]   = load_hr_i;
  assign ld[F_WDAY] = load_wday_i;
  assign ld[F_MDAY] = load_mday_i;
  assign ld[F_MON]  = load_mon_i;
  assign ld[F_YEAR] = load_year_i;

  assign tick_run = tick_i && (osc_i == OSC_RUN);
  assign step     = tick_run && !busy_q;
  assign end_ev   = busy_q && (cnt_q == '0);
  assign ld_tm    = regs_to_tm(vis_q, bin_mode_i, hr24_i);

  rtc_time_core #(.BASE_YEAR(BASE_YEAR)) i_core (
    .clk_i, .rst_ni, .step_i(step), .load_i(sync_q), .load_tm_i(ld_tm), .tm_o(tm)
  );

  rtc_fmt i_fmt (.tm_i(tm), .bin_i(bin_mode_i), .h24_i(hr24_i), .regs_o(enc));

  rtc_alarm i_alarm (
    .tm_i(tm), .alarm_i({alarm_hr_i, alarm_min_i, alarm_sec_i}),
    .bin_i(bin_mode_i), .h24_i(hr24_i), .match_o(alarm_hit)
  );

  assign afire     = end_ev && alarm_en_i && alarm_hit;
  assign flags_new = end_ev ? {(upd_irq_en_i || afire), 1'b0, afire, 1'b1, 4'b0} : 8'h00;

  // update window sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      uip_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (step) begin
      busy_q <= 1'b1;
      uip_q  <= !set_i;
      cnt_q  <= CW'(UIP_DLY - 1);
    end else if (end_ev) begin
      busy_q <= 1'b0;
      uip_q  <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      set_q  <= set_i;
      sync_q <= !set_i && (load_i || set_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_q <= '0;
      vis_q[F_WDAY] <= 8'h01;
      vis_q[F_MDAY] <= 8'h01;
      vis_q[F_MON]  <= 8'h01;
    end else if (load_i) begin
      vis_q <= ld;
    end else if (end_ev && !set_i) begin
      vis_q <= enc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flag_clr_i ? 8'h00 : flags_q) | flags_new;
  end

  assign sec_o   = vis_q[F_SEC];
  assign min_o   = vis_q[F_MIN];
  assign hr_o    = vis_q[F_HR];
  assign wday_o  = vis_q[F_WDAY];
  assign mday_o  = vis_q[F_MDAY];
  assign mon_o   = vis_q[F_MON];
  assign year_o  = vis_q[F_YEAR];
  assign uip_o   = uip_q;
  assign flags_o = flags_q;
  assign irq_o   = flags_q[7];

  assert_stopped_no_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && osc_i != OSC_RUN && !busy_q && !sync_q) |=> $stable(tm));

  assert_uip_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uip_o) |-> ($past(tick_i) && $past(osc_i) == OSC_RUN && !$past(set_i)));

  assert_uf_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[4]) |-> $past(end_ev));

  assert_irq_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(upd_irq_en_i) || $past(alarm_en_i)));

  assert_af_needs_aie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[5]) |-> ($past(alarm_en_i) && $past(alarm_hit)));

  assert_set_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !load_i) |=> $stable(sec_o));

  assert_uip_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uip_o |-> busy_q);
endmodule

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
  localparam int DLY = 8;

  logic clk = 0, rst_n = 0;
  logic tick = 0, bin = 0, h24 = 1, set = 0, aie = 0, uie = 0, load = 0, fclr = 0;
  logic [2:0] osc = 3'b010;
  logic [7:0] a_sec = 0, a_min = 0, a_hr = 0;
  logic [6:0][7:0] ldv = '0;   // 6 year,5 mon,4 mday,3 wday,2 hr,1 min,0 sec
  logic [7:0] sec, min, hr, wday, mday, mon, year, flags;
  logic uip, irq;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  rtc_calendar #(.BASE_YEAR(2000), .UIP_DLY(DLY)) i_rtc_calendar (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .osc_i(osc), .bin_mode_i(bin),
    .hr24_i(h24), .set_i(set), .alarm_en_i(aie), .upd_irq_en_i(uie),
    .alarm_sec_i(a_sec), .alarm_min_i(a_min), .alarm_hr_i(a_hr), .load_i(load),
    .load_sec_i(ldv[0]), .load_min_i(ldv[1]), .load_hr_i(ldv[2]), .load_wday_i(ldv[3]),
    .load_mday_i(ldv[4]), .load_mon_i(ldv[5]), .load_year_i(ldv[6]), .flag_clr_i(fclr),
    .sec_o(sec), .min_o(min), .hr_o(hr), .wday_o(wday), .mday_o(mday), .mon_o(mon),
    .year_o(year), .uip_o(uip), .flags_o(flags), .irq_o(irq)
  );

  typedef struct packed {
    logic bin;
    logic h24;
    logic [6:0][7:0] ld;
    logic [6:0][7:0] ex;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, {8'h99,8'h12,8'h31,8'h07,8'h23,8'h59,8'h59}, {8'h00,8'h01,8'h01,8'h01,8'h00,8'h00,8'h00}},
    '{1'b0, 1'b1, {8'h24,8'h02,8'h28,8'h03,8'h23,8'h59,8'h59}, {8'h24,8'h02,8'h29,8'h04,8'h00,8'h00,8'h00}},
    '{1'b0, 1'b1, {8'h23,8'h02,8'h28,8'h03,8'h23,8'h59,8'h59}, {8'h23,8'h03,8'h01,8'h04,8'h00,8'h00,8'h00}},
    '{1'b0, 1'b1, {8'h00,8'h02,8'h28,8'h02,8'h23,8'h59,8'h59}, {8'h00,8'h02,8'h29,8'h03,8'h00,8'h00,8'h00}},
    '{1'b1, 1'b1, {8'h05,8'h04,8'h1E,8'h06,8'h17,8'h3B,8'h3B}, {8'h05,8'h05,8'h01,8'h07,8'h00,8'h00,8'h00}},
    '{1'b0, 1'b0, {8'h10,8'h06,8'h15,8'h02,8'h11,8'h59,8'h59}, {8'h10,8'h06,8'h15,8'h02,8'h80,8'h00,8'h00}},
    '{1'b0, 1'b0, {8'h10,8'h06,8'h15,8'h02,8'h91,8'h59,8'h59}, {8'h10,8'h06,8'h16,8'h03,8'h00,8'h00,8'h00}},
    '{1'b1, 1'b0, {8'h0A,8'h06,8'h0F,8'h02,8'h8B,8'h3B,8'h3B}, {8'h0A,8'h06,8'h10,8'h03,8'h00,8'h00,8'h00}},
    '{1'b0, 1'b1, {8'h21,8'h09,8'h30,8'h05,8'h12,8'h34,8'h56}, {8'h21,8'h09,8'h30,8'h05,8'h12,8'h34,8'h57}},
    '{1'b0, 1'b0, {8'h10,8'h06,8'h15,8'h02,8'h80,8'h59,8'h59}, {8'h10,8'h06,8'h15,8'h02,8'h81,8'h00,8'h00}},
    '{1'b1, 1'b1, {8'h63,8'h0C,8'h1F,8'h07,8'h17,8'h3B,8'h3B}, {8'h00,8'h01,8'h01,8'h01,8'h00,8'h00,8'h00}}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [6:0][7:0] v);
    ldv = v;
    load = 1;
    @(negedge clk);
    load = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1;
    @(negedge clk);
    tick = 0;
    repeat (DLY + 4) @(negedge clk);
  endtask

  task automatic do_clr();
    fclr = 1;
    @(negedge clk);
    fclr = 0;
  endtask

  task automatic chk_time(input string req, input logic [6:0][7:0] e);
    chk(req, sec, e[0]);  chk(req, min, e[1]);  chk(req, hr, e[2]);
    chk(req, wday, e[3]); chk(req, mday, e[4]); chk(req, mon, e[5]);
    chk(req, year, e[6]);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk_time("R11 reset", {8'h00,8'h01,8'h01,8'h01,8'h00,8'h00,8'h00});
    chk("R11 reset uip", {7'b0, uip}, 8'h00);
    chk("R11 reset flags", flags, 8'h00);
    chk("R11 reset irq", {7'b0, irq}, 8'h00);

    // table: R2 R3 R4 R5 R10
    for (int i = 0; i < NV; i++) begin
      bin = VECS[i].bin;
      h24 = VECS[i].h24;
      do_load(VECS[i].ld);
      chk_time("R10 load", VECS[i].ld);
      do_tick();
      chk_time($sformatf("R2/R3/R4/R5 vec %0d", i), VECS[i].ex);
      do_clr();
    end

    // R6 update window timing, R7 UF without IRQ
    bin = 0; h24 = 1;
    do_load({8'h21,8'h09,8'h30,8'h05,8'h12,8'h34,8'h56});
    tick = 1;
    @(negedge clk);
    tick = 0;
    chk("R6 uip high", {7'b0, uip}, 8'h01);
    chk("R6 sec held", sec, 8'h56);
    repeat (DLY - 1) @(negedge clk);
    chk("R6 uip last", {7'b0, uip}, 8'h01);
    chk("R6 no UF yet", flags, 8'h00);
    @(negedge clk);
    chk("R6 uip low", {7'b0, uip}, 8'h00);
    chk("R6 refreshed", sec, 8'h57);
    chk("R7 UF only", flags, 8'h10);
    chk("R7 no irq", {7'b0, irq}, 8'h00);
    do_clr();
    chk("R11 clear", flags, 8'h00);

    // R7 UIE
    uie = 1;
    do_tick();
    chk("R7 UIE flags", flags, 8'h90);
    chk("R7 UIE irq", {7'b0, irq}, 8'h01);
    do_clr();
    chk("R11 clear irq", {7'b0, irq}, 8'h00);
    uie = 0;

    // R1 oscillator stopped
    osc = 3'b000;
    do_tick();
    chk("R1 stopped sec", sec, 8'h58);
    chk("R1 stopped flags", flags, 8'h00);
    osc = 3'b110;
    do_tick();
    chk("R1 other code sec", sec, 8'h58);
    chk("R1 other code flags", flags, 8'h00);
    osc = 3'b010;

    // R8 alarm
    do_load({8'h21,8'h09,8'h30,8'h05,8'h10,8'h20,8'h30});
    aie = 1; a_sec = 8'h31; a_min = 8'hC0; a_hr = 8'hFF;
    do_tick();
    chk("R8 alarm fire", flags, 8'hB0);
    chk("R8 alarm irq", {7'b0, irq}, 8'h01);
    do_clr();
    a_sec = 8'h45;
    do_tick();
    chk("R8 alarm miss", flags, 8'h10);
    do_clr();
    aie = 0; a_sec = 8'h33;
    do_tick();
    chk("R8 AIE off", flags, 8'h10);
    chk("R8 AIE off irq", {7'b0, irq}, 8'h00);
    do_clr();

    // R9 SET behaviour
    set = 1;
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
    chk("R9 no uip", {7'b0, uip}, 8'h00);
    repeat (DLY + 3) @(negedge clk);
    chk("R9 frozen", sec, 8'h33);
    chk("R9 UF still", flags, 8'h10);
    do_clr();
    do_load({8'h21,8'h09,8'h30,8'h05,8'h05,8'h06,8'h07});
    chk("R9 load visible", sec, 8'h07);
    do_tick();
    chk("R9 still frozen", sec, 8'h07);
    set = 0;
    repeat (2) @(negedge clk);
    do_tick();
    chk("R9 resume sec", sec, 8'h08);
    chk("R9 resume min", min, 8'h06);
    chk("R9 resume hr", hr, 8'h05);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule